// File: doc/BRIEF.md
# Synthesizer Configuration Loader with Parallel and Serial Paths

This block keeps the control settings of a PLL clock synthesizer in one set of registers: a 9-bit feedback divide value, a 2-bit post-divide select, a 3-bit test select and a 4-bit spread-spectrum mode field. Two load paths share these registers.

The parallel path takes the feedback and post-divide pins when its strobe rises. The serial path uses three wires. Each rising edge of a serial clock shifts one bit into an 18-bit shift register. A falling edge on a separate load strobe then moves the whole frame into the registers.

All control pins are asynchronous to the system clock. They are synchronized and edge-detected inside the block. While the parallel strobe is high, the parallel path owns the registers and serial transfers are refused.

The block also drives outputs decoded from the settings: the post-divide ratio as a one-hot value, a bypass indication and a lock-range warning for the feedback value.

Top module: `synth_cfg_loader`

## Requirements
- R1: Synchronous reset (rst high) clears the shift register and sets the registers to feedback 256, post-divide select 0, test select 0 and spread mode 0. After reset, post_div reads 1, bypass reads 0 and m_range_err reads 0.
- R2: A rising edge on par_load stores par_m into cfg_m and par_n into cfg_n. cfg_t and cfg_ss keep their values.
- R3: Changes on par_m or par_n with no rising edge of par_load leave cfg_m and cfg_n unchanged. This holds whether par_load is steady low or steady high.
- R4: Each rising edge of ser_clk shifts ser_data into the shift register. The serial stream is sent most significant bit first. The 18-bit frame is laid out as T in bits [17:15], SS in bits [14:11], N in bits [10:9] and M in bits [8:0], so the last bit shifted in is M bit 0. A falling edge of ser_load while par_load is low copies all four fields into cfg_t, cfg_ss, cfg_n and cfg_m.
- R5: A falling edge of ser_load while par_load is high leaves all four registers unchanged, so the parallel path has priority.
- R6: Shifting with no falling edge of ser_load, and a rising edge of ser_load, leave the registers unchanged.
- R7: post_div is one-hot and gives the divide ratio. cfg_n = 0, 1, 2 and 3 give 1, 2, 4 and 8 (4'b0001, 4'b0010, 4'b0100, 4'b1000).
- R8: bypass is high exactly when cfg_t equals 3'b110.
- R9: m_range_err is high exactly when cfg_m is below 200 or above 400.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_load | input | 1 | Parallel load strobe; the rising edge captures, the high level blocks serial loads |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel post-divide select |
| ser_clk | input | 1 | Serial shift clock; shifts on its rising edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_load | input | 1 | Serial transfer strobe; transfers on its falling edge |
| cfg_m | output | 9 | Registered feedback divide value |
| cfg_n | output | 2 | Registered post-divide select |
| cfg_t | output | 3 | Registered test select |
| cfg_ss | output | 4 | Registered spread-spectrum mode |
| post_div | output | 4 | One-hot post-divide ratio |
| bypass | output | 1 | High when the test select is the bypass code |
| m_range_err | output | 1 | High when the feedback value is outside 200..400 |

## Verification
The hardest case to reach is a serial transfer that arrives while the parallel path holds the registers. The shift register must already hold a full frame that differs from the current settings, and the parallel strobe must be high, before the serial strobe falls. The bench sets this up by raising par_load and then shifting a frame with a bypass code and a new feedback value. It then drops ser_load and checks that nothing changed. Finally it releases par_load and strobes again, which shows the refused frame was waiting in the shift register.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 3;
  localparam int SS_W    = 4;
  localparam int FRAME_W = T_W + SS_W + N_W + M_W;
  localparam int DIV_W   = 1 << N_W;

  typedef struct packed {
    logic [T_W-1:0]  t;
    logic [SS_W-1:0] ss;
    logic [N_W-1:0]  n;
    logic [M_W-1:0]  m;
  } cfg_word_t;
endpackage

// File: rtl/scl_sync_bank.sv
module scl_sync_bank #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/scl_edge_det.sv
module scl_edge_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/scl_shifter.sv
module scl_shifter #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
  import scl_pkg::*;
#(
  parameter int M_DEFAULT = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               par_rise,
  input  logic               par_level,
  input  logic               ser_fall,
  input  logic [M_W-1:0]     par_m,
  input  logic [N_W-1:0]     par_n,
  input  logic [FRAME_W-1:0] frame,
  output cfg_word_t          cfg
);
  cfg_word_t frame_w;
  assign frame_w = cfg_word_t'(frame);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.m  <= M_W'(M_DEFAULT);
      cfg.n  <= '0;
      cfg.t  <= '0;
      cfg.ss <= '0;
    end else if (par_rise) begin
      cfg.m <= par_m;
      cfg.n <= par_n;
    end else if (ser_fall && !par_level) begin
      cfg <= frame_w;
    end
  end
endmodule

// File: rtl/scl_decode.sv
module scl_decode
  import scl_pkg::*;
#(
  parameter int             M_LO        = 200,
  parameter int             M_HI        = 400,
  parameter logic [T_W-1:0] BYPASS_CODE = 3'b110
) (
  input  logic             clk,
  input  logic             rst,
  input  cfg_word_t        cfg,
  output logic [DIV_W-1:0] post_div,
  output logic             bypass,
  output logic             m_range_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      post_div    <= DIV_W'(1);
      bypass      <= 1'b0;
      m_range_err <= 1'b0;
    end else begin
      post_div    <= DIV_W'(1) << cfg.n;
      bypass      <= (cfg.t == BYPASS_CODE);
      m_range_err <= (int'(cfg.m) < M_LO) || (int'(cfg.m) > M_HI);
    end
  end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import scl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int M_DEFAULT   = 256,
  parameter int M_LO        = 200,
  parameter int M_HI        = 400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             par_load,
  input  logic [M_W-1:0]   par_m,
  input  logic [N_W-1:0]   par_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_load,
  output logic [M_W-1:0]   cfg_m,
  output logic [N_W-1:0]   cfg_n,
  output logic [T_W-1:0]   cfg_t,
  output logic [SS_W-1:0]  cfg_ss,
  output logic [DIV_W-1:0] post_div,
  output logic             bypass,
  output logic             m_range_err
);
  localparam int BUS_W = 4 + M_W + N_W;

  logic [BUS_W-1:0]   raw_bus, sync_bus;
  logic               pl_s, sc_s, sd_s, sl_s;
  logic [M_W-1:0]     pm_s;
  logic [N_W-1:0]     pn_s;
  logic [2:0]         strobe_lvl, strobe_rise, strobe_fall;
  logic               par_rise, ser_rise, ser_fall;
  logic [FRAME_W-1:0] shreg;
  cfg_word_t          cfg;

  assign raw_bus = {par_load, par_m, par_n, ser_clk, ser_data, ser_load};

  scl_sync_bank #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_bus), .q(sync_bus)
  );

  assign {pl_s, pm_s, pn_s, sc_s, sd_s, sl_s} = sync_bus;

  assign strobe_lvl = {pl_s, sc_s, sl_s};

  scl_edge_det #(.W(3)) u_edge (
    .clk(clk), .rst(rst), .lvl(strobe_lvl),
    .rise(strobe_rise), .fall(strobe_fall)
  );

  assign par_rise = strobe_rise[2];
  assign ser_rise = strobe_rise[1];
  assign ser_fall = strobe_fall[0];

  scl_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(ser_rise), .din(sd_s), .q(shreg)
  );

  scl_cfg_regs #(.M_DEFAULT(M_DEFAULT)) u_regs (
    .clk(clk), .rst(rst), .par_rise(par_rise), .par_level(pl_s),
    .ser_fall(ser_fall), .par_m(pm_s), .par_n(pn_s), .frame(shreg),
    .cfg(cfg)
  );

  scl_decode #(.M_LO(M_LO), .M_HI(M_HI)) u_dec (
    .clk(clk), .rst(rst), .cfg(cfg),
    .post_div(post_div), .bypass(bypass), .m_range_err(m_range_err)
  );

  assign cfg_m  = cfg.m;
  assign cfg_n  = cfg.n;
  assign cfg_t  = cfg.t;
  assign cfg_ss = cfg.ss;
endmodule

// File: rtl/scl_checker.sv
module scl_checker
  import scl_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               par_rise,
  input logic               pl_s,
  input logic               ser_rise,
  input logic               ser_fall,
  input logic               sd_s,
  input logic [M_W-1:0]     pm_s,
  input logic [N_W-1:0]     pn_s,
  input logic [FRAME_W-1:0] shreg,
  input logic [M_W-1:0]     cfg_m,
  input logic [N_W-1:0]     cfg_n,
  input logic [T_W-1:0]     cfg_t,
  input logic [SS_W-1:0]    cfg_ss,
  input logic [DIV_W-1:0]   post_div,
  input logic               m_range_err
);
  a_r2_par_capture: assert property (@(posedge clk) disable iff (rst)
    par_rise |=> (cfg_m == $past(pm_s)) && (cfg_n == $past(pn_s))
                 && $stable(cfg_t) && $stable(cfg_ss));

  a_r4_shift_in: assert property (@(posedge clk) disable iff (rst)
    ser_rise |=> shreg[0] == $past(sd_s));

  a_r4_ser_transfer: assert property (@(posedge clk) disable iff (rst)
    (ser_fall && !pl_s) |=> (cfg_m == $past(shreg[8:0])) && (cfg_t == $past(shreg[17:15])));

  a_r5_par_priority: assert property (@(posedge clk) disable iff (rst)
    (ser_fall && pl_s && !par_rise) |=> $stable(cfg_t) && $stable(cfg_ss)
                                        && $stable(cfg_m) && $stable(cfg_n));

  a_r7_onehot_div: assert property (@(posedge clk) disable iff (rst)
    $countones(post_div) == 1);

  a_r9_in_range: assert property (@(posedge clk) disable iff (rst)
    (cfg_m >= 9'd200 && cfg_m <= 9'd400) |=> !m_range_err);
endmodule

bind synth_cfg_loader scl_checker u_chk (
  .clk(clk), .rst(rst), .par_rise(par_rise), .pl_s(pl_s),
  .ser_rise(ser_rise), .ser_fall(ser_fall), .sd_s(sd_s),
  .pm_s(pm_s), .pn_s(pn_s), .shreg(shreg),
  .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t), .cfg_ss(cfg_ss),
  .post_div(post_div), .m_range_err(m_range_err)
);

// File: tb/synth_cfg_loader_test.sv
`timescale 1ns/1ps
module synth_cfg_loader_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       par_load = 1'b0;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic       ser_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic       ser_load = 1'b1;
  logic [8:0] cfg_m;
  logic [1:0] cfg_n;
  logic [2:0] cfg_t;
  logic [3:0] cfg_ss;
  logic [3:0] post_div;
  logic       bypass;
  logic       m_range_err;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  synth_cfg_loader uut (
    .clk(clk), .rst(rst), .par_load(par_load), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t), .cfg_ss(cfg_ss),
    .post_div(post_div), .bypass(bypass), .m_range_err(m_range_err)
  );

  // {serial?, frame {T,SS,N,M}, expected post_div, bypass, range_err}
  localparam int VW = 25;
  localparam logic [VW-1:0] VEC [8] = '{
    {1'b1, 3'b000, 4'b0101, 2'b01, 9'd300, 4'b0010, 1'b0, 1'b0},
    {1'b0, 3'b000, 4'b0000, 2'b10, 9'd199, 4'b0100, 1'b0, 1'b1},
    {1'b1, 3'b110, 4'b0011, 2'b11, 9'd400, 4'b1000, 1'b1, 1'b0},
    {1'b0, 3'b000, 4'b0000, 2'b00, 9'd200, 4'b0001, 1'b1, 1'b0},
    {1'b1, 3'b101, 4'b1111, 2'b10, 9'd401, 4'b0100, 1'b0, 1'b1},
    {1'b0, 3'b000, 4'b0000, 2'b01, 9'd511, 4'b0010, 1'b0, 1'b1},
    {1'b1, 3'b111, 4'b0000, 2'b00, 9'd250, 4'b0001, 1'b0, 1'b0},
    {1'b0, 3'b000, 4'b0000, 2'b11, 9'd0,   4'b1000, 1'b0, 1'b1}
  };

  logic [8:0] em;
  logic [1:0] en;
  logic [2:0] et;
  logic [3:0] ess;

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wait_clk(3);
    rst = 1'b0;
    wait_clk(6);
  endtask

  task automatic par_strobe(input logic [8:0] m, input logic [1:0] n);
    par_m = m;
    par_n = n;
    wait_clk(4);
    par_load = 1'b1;
    wait_clk(8);
    par_load = 1'b0;
    wait_clk(4);
  endtask

  task automatic shift_frame(input logic [17:0] f);
    for (int i = 17; i >= 0; i--) begin
      ser_data = f[i];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
    wait_clk(4);
  endtask

  task automatic ser_strobe();
    ser_load = 1'b0;
    wait_clk(8);
    ser_load = 1'b1;
    wait_clk(4);
  endtask

  task automatic chk_cfg(input string req);
    chk(req, "cfg_m", int'(cfg_m), int'(em));
    chk(req, "cfg_n", int'(cfg_n), int'(en));
    chk(req, "cfg_t", int'(cfg_t), int'(et));
    chk(req, "cfg_ss", int'(cfg_ss), int'(ess));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset defaults
    em = 9'd256; en = 2'd0; et = 3'd0; ess = 4'd0;
    chk_cfg("R1");
    chk("R1", "post_div", int'(post_div), 1);
    chk("R1", "bypass", int'(bypass), 0);
    chk("R1", "m_range_err", int'(m_range_err), 0);

    // table: R2 parallel, R4 serial, R7 ratio, R8 bypass, R9 range
    for (int v = 0; v < 8; v++) begin
      logic [VW-1:0] e;
      logic [17:0]   f;
      e = VEC[v];
      f = e[23:6];
      if (e[24]) begin
        shift_frame(f);
        ser_strobe();
        et = f[17:15]; ess = f[14:11]; en = f[10:9]; em = f[8:0];
        chk_cfg("R4");
      end else begin
        par_strobe(f[8:0], f[10:9]);
        en = f[10:9]; em = f[8:0];
        chk_cfg("R2");
      end
      chk("R7", "post_div", int'(post_div), int'(e[5:2]));
      chk("R8", "bypass", int'(bypass), int'(e[1]));
      chk("R9", "m_range_err", int'(m_range_err), int'(e[0]));
    end

    // R3: parallel pins change without an edge, par_load low then steady high
    par_m = 9'd123; par_n = 2'd2;
    wait_clk(10);
    chk_cfg("R3");
    par_load = 1'b1;
    wait_clk(8);
    em = 9'd123; en = 2'd2;
    chk_cfg("R2");
    par_m = 9'd77; par_n = 2'd1;
    wait_clk(10);
    chk_cfg("R3");

    // R5: serial transfer refused while par_load high
    shift_frame({3'b110, 4'b1010, 2'b11, 9'd333});
    ser_strobe();
    chk_cfg("R5");
    chk("R5", "bypass", int'(bypass), 0);
    par_load = 1'b0;
    wait_clk(6);
    ser_strobe();
    et = 3'b110; ess = 4'b1010; en = 2'b11; em = 9'd333;
    chk_cfg("R4");
    chk("R8", "bypass", int'(bypass), 1);

    // R6: shifting and ser_load rising do not load
    ser_load = 1'b0;
    wait_clk(8);
    chk_cfg("R4");
    shift_frame({3'b001, 4'b0001, 2'b00, 9'd210});
    ser_load = 1'b1;
    wait_clk(8);
    chk_cfg("R6");

    // R1: reset clears shifter, so a bare transfer loads all zeros
    do_reset();
    em = 9'd256; en = 2'd0; et = 3'd0; ess = 4'd0;
    chk_cfg("R1");
    ser_strobe();
    em = 9'd0;
    chk_cfg("R1");
    chk("R9", "m_range_err", int'(m_range_err), 1);
    chk("R7", "post_div", int'(post_div), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule